// File: doc/BRIEF.md
# Banked Interrupt Aggregation Controller

This block collects a wide set of interrupt lines and folds them into one interrupt output for a host. The lines are grouped into banks of 32. In each bank software can set and clear enable bits through separate write-one registers, pick a trigger type for each line, read the latched and the pending status, clear latched status and raise a software interrupt on any line.

Two gates sit in front of the single output. A master enable turns the whole controller off while it is being configured. A separate output enable lets an interrupt handler mask the output while it services the sources, without losing any latched status. A read-only identification word reports the line count and the version.

All registers are reached through a simple 32-bit read/write port. Read data is registered and appears one clock after the read strobe. The interrupt output is also registered.

Top module: `irq_aggregator`

## Requirements
- R1: The word at byte offset 0x000 is read-only and returns the line count `NUM_LINES` in bits 15:0 and `VERSION` in bits 31:16.
- R2: After reset, `irq_out` is 0, every enable, type and status bit is 0, the master enable (bit 0 of offset 0x004) is 0 and the output enable (bit 0 of offset 0x00C) is 1.
- R3: Bank b starts at byte 0x100 + 0x20·b. Writing ones at bank offset 0x00 sets the matching enable bits, and writing ones at offset 0x04 clears them. Reads at either offset return the enable mask.
- R4: A line whose type bit (bank offset 0x0C) is 0 is level-sensitive, so its raw status (read at bank offset 0x08) follows the input. The pending word at bank offset 0x10 reads raw status AND enable.
- R5: A line whose type bit is 1 latches raw status on a 0-to-1 input transition and keeps it after the input falls, until a one is written at bank offset 0x08 for that bit.
- R6: When a rising edge on an edge-type line and a status-clear write to the same bit fall in the same cycle, the bit ends up set.
- R7: Writing ones at bank offset 0x14 sets raw status for those lines until they are cleared through offset 0x08. Reads at 0x14 return 0.
- R8: `irq_out` is 1 exactly one clock after master enable, output enable and any pending bit in any bank are all 1 together, and 0 one clock after any of them is 0.
- R9: Bit 0 of the word at offset 0x008 reads master enable AND any pending bit. It does not depend on the output enable.
- R10: Writing 0 to the output enable masks `irq_out` while raw status is kept. Writing 1 brings the output back.
- R11: Each bank acts on its own slice of `irq_lines` (bank b owns lines 32·b to 32·b+31), and a line in any bank can drive `irq_out`.
- R12: Writes to read-only words, to unmapped offsets or to offsets that are not word-aligned change no state. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one clock after `reg_rd` |
| irq_lines | input | NUM_LINES | Incoming interrupt lines, synchronous to `clk` |
| irq_out | output | 1 | Aggregated interrupt to the host |

## Verification
Two collisions are provoked on purpose. In the first, an edge-type line rises in the same clock as a status-clear write to that bit. The bench drives both in one cycle, then reads raw status back, and the bit must be set. In the second, the output enable is dropped while a software interrupt is latched. Here `irq_out` must fall one cycle later while the master status bit and the raw status both stay at 1, and re-enabling the output must raise `irq_out` again.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int BANK_W = 32;

  // register select inside one bank window (word offset)
  localparam logic [2:0] BR_ENSET  = 3'd0;
  localparam logic [2:0] BR_ENCLR  = 3'd1;
  localparam logic [2:0] BR_STCLR  = 3'd2;
  localparam logic [2:0] BR_TYPE   = 3'd3;
  localparam logic [2:0] BR_PEND   = 3'd4;
  localparam logic [2:0] BR_SWTRIG = 3'd5;

  // global words
  localparam logic [1:0] GR_ID     = 2'd0;
  localparam logic [1:0] GR_MASTER = 2'd1;
  localparam logic [1:0] GR_MSTAT  = 2'd2;
  localparam logic [1:0] GR_OUTEN  = 2'd3;
endpackage

// File: rtl/irqagg_bank.sv
module irqagg_bank
  import irqagg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] lines,
  input  logic              wr,
  input  logic [2:0]        sel,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] en_o,
  output logic [BANK_W-1:0] raw_o,
  output logic [BANK_W-1:0] type_o,
  output logic [BANK_W-1:0] pend_o
);
  logic [BANK_W-1:0] en_q, typ_q, prev_q, edge_q, sw_q;
  logic [BANK_W-1:0] rise, clr, swset;

  assign rise  = lines & ~prev_q;
  assign clr   = (wr && sel == BR_STCLR)  ? wdata : '0;
  assign swset = (wr && sel == BR_SWTRIG) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      typ_q  <= '0;
      prev_q <= '0;
      edge_q <= '0;
      sw_q   <= '0;
    end else begin
      prev_q <= lines;
      if (wr && sel == BR_ENSET) en_q <= en_q | wdata;
      if (wr && sel == BR_ENCLR) en_q <= en_q & ~wdata;
      if (wr && sel == BR_TYPE)  typ_q <= wdata;
      // a new edge wins over a clear in the same cycle
      edge_q <= (edge_q & ~clr) | (rise & typ_q);
      sw_q   <= (sw_q & ~clr) | swset;
    end
  end

  assign raw_o  = (typ_q & edge_q) | (~typ_q & lines) | sw_q;
  assign en_o   = en_q;
  assign type_o = typ_q;
  assign pend_o = raw_o & en_q;

  p_enset_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == BR_ENSET) |=> ((en_q & $past(wdata)) == $past(wdata)));

  p_enclr_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == BR_ENCLR) |=> ((en_q & $past(wdata)) == '0));

  p_swset_r7: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == BR_SWTRIG) |=> ((sw_q & $past(wdata)) == $past(wdata)));

  p_edge_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (|(rise & typ_q)) |=> ((edge_q & $past(rise & typ_q)) == $past(rise & typ_q)));
endmodule

// File: rtl/irqagg_gate.sv
module irqagg_gate (
  input  logic clk,
  input  logic rst,
  input  logic wr_master,
  input  logic wr_outen,
  input  logic wbit,
  input  logic any_pend,
  output logic master_o,
  output logic outen_o,
  output logic mstat_o,
  output logic irq_o
);
  logic master_q, outen_q, irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      master_q <= 1'b0;
      outen_q  <= 1'b1;
      irq_q    <= 1'b0;
    end else begin
      if (wr_master) master_q <= wbit;
      if (wr_outen)  outen_q  <= wbit;
      irq_q <= master_q & outen_q & any_pend;
    end
  end

  assign master_o = master_q;
  assign outen_o  = outen_q;
  assign mstat_o  = master_q & any_pend;
  assign irq_o    = irq_q;

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(master_q) && $past(outen_q)));

  p_irq_follows_r8: assert property (@(posedge clk) disable iff (rst)
    (master_q && outen_q && any_pend) |=> irq_q);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int          NUM_LINES = 64,
  parameter logic [15:0] VERSION   = 16'h0102,
  parameter int          ADDR_W    = 10,
  parameter int          BANK_BASE = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_LINES-1:0] irq_lines,
  output logic                 irq_out
);
  localparam int NUM_BANKS = NUM_LINES / BANK_W;
  localparam int WORD_W    = ADDR_W - 2;
  localparam int BASE_WORD = BANK_BASE / 4;
  localparam int BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  initial begin
    if (NUM_LINES == 0 || (NUM_LINES % BANK_W) != 0)
      $error("NUM_LINES must be a nonzero multiple of 32");
  end

  logic [WORD_W-1:0]   word, boff;
  logic [WORD_W-4:0]   bnum;
  logic [BIDX_W-1:0]   bidx;
  logic [2:0]          bsel;
  logic                aligned, glob_hit, bank_hit;

  assign word     = reg_addr[ADDR_W-1:2];
  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign glob_hit = aligned && (word < WORD_W'(4));
  assign boff     = word - WORD_W'(BASE_WORD);
  assign bnum     = boff[WORD_W-1:3];
  assign bsel     = boff[2:0];
  assign bidx     = bnum[BIDX_W-1:0];
  assign bank_hit = aligned && (word >= WORD_W'(BASE_WORD)) &&
                    (bnum < (WORD_W-3)'(NUM_BANKS));

  logic [BANK_W-1:0] en_a   [NUM_BANKS];
  logic [BANK_W-1:0] raw_a  [NUM_BANKS];
  logic [BANK_W-1:0] typ_a  [NUM_BANKS];
  logic [BANK_W-1:0] pend_a [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irqagg_bank u_bank (
      .clk    (clk),
      .rst    (rst),
      .lines  (irq_lines[b*BANK_W +: BANK_W]),
      .wr     (reg_wr && bank_hit && (bidx == BIDX_W'(b))),
      .sel    (bsel),
      .wdata  (reg_wdata),
      .en_o   (en_a[b]),
      .raw_o  (raw_a[b]),
      .type_o (typ_a[b]),
      .pend_o (pend_a[b])
    );
  end

  logic any_pend;
  always_comb begin
    any_pend = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) any_pend = any_pend | (|pend_a[b]);
  end

  logic master, outen, mstat;
  irqagg_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .wr_master (reg_wr && glob_hit && word[1:0] == GR_MASTER),
    .wr_outen  (reg_wr && glob_hit && word[1:0] == GR_OUTEN),
    .wbit      (reg_wdata[0]),
    .any_pend  (any_pend),
    .master_o  (master),
    .outen_o   (outen),
    .mstat_o   (mstat),
    .irq_o     (irq_out)
  );

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (glob_hit) begin
      case (word[1:0])
        GR_ID:     rd_val = {VERSION, 16'(NUM_LINES)};
        GR_MASTER: rd_val = {31'd0, master};
        GR_MSTAT:  rd_val = {31'd0, mstat};
        default:   rd_val = {31'd0, outen};
      endcase
    end else if (bank_hit) begin
      case (bsel)
        BR_ENSET, BR_ENCLR: rd_val = en_a[bidx];
        BR_STCLR:           rd_val = raw_a[bidx];
        BR_TYPE:            rd_val = typ_a[bidx];
        BR_PEND:            rd_val = pend_a[bidx];
        default:            rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  p_id_stable_r1: assert property (@(posedge clk) disable iff (rst)
    (glob_hit && word[1:0] == GR_ID && reg_rd) |=> (reg_rdata == {VERSION, 16'(NUM_LINES)}));
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int NL = 64;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NL-1:0] irq_lines = '0;
  logic          irq_out;

  always #4 clk = ~clk;

  irq_aggregator #(.NUM_LINES(NL), .ADDR_W(AW)) i_irq_aggregator (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_lines(irq_lines), .irq_out(irq_out)
  );

  typedef struct { logic [31:0] exp; string req; } item_t;
  item_t sb[$];
  int compared = 0, mismatched = 0;
  logic rd_q = 1'b0;
  bit done = 1'b0;

  localparam logic [AW-1:0] A_ID = 10'h000, A_MST = 10'h004, A_MSTAT = 10'h008,
                            A_OEN = 10'h00C;
  localparam logic [AW-1:0] B0 = 10'h100, B1 = 10'h120;
  localparam logic [AW-1:0] O_ENSET = 10'h00, O_ENCLR = 10'h04, O_STCLR = 10'h08,
                            O_TYPE = 10'h0C, O_PEND = 10'h10, O_SW = 10'h14;

  always @(posedge clk) rd_q <= reg_rd;

  // monitor: pop expected read values and compare
  always @(negedge clk) begin
    if (rd_q) begin
      item_t it;
      compared++;
      if (sb.size() == 0) begin
        mismatched++;
        $display("FAIL scoreboard: got %h expected nothing", reg_rdata);
      end else begin
        it = sb.pop_front();
        if (reg_rdata !== it.exp) begin
          mismatched++;
          $display("FAIL %s: got %h expected %h", it.req, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string req);
    item_t it;
    it.exp = e; it.req = req;
    sb.push_back(it);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string req);
    compared++;
    if (irq_out !== e) begin
      mismatched++;
      $display("FAIL %s: irq_out got %b expected %b", req, irq_out, e);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    // R2 reset state, R1 identification
    chk_irq(1'b0, "R2");
    rd(A_ID, 32'h0102_0040, "R1");
    rd(A_MST, 32'd0, "R2");
    rd(A_OEN, 32'd1, "R2");
    rd(B0 + O_ENSET, 32'd0, "R2");
    rd(B0 + O_TYPE, 32'd0, "R2");
    // R3 enable set / clear
    wr(B0 + O_ENSET, 32'h0000_00FF);
    wr(B0 + O_ENSET, 32'h0000_0100);
    rd(B0 + O_ENSET, 32'h0000_01FF, "R3");
    wr(B0 + O_ENCLR, 32'h0000_00F0);
    rd(B0 + O_ENCLR, 32'h0000_010F, "R3");
    wr(A_MST, 32'd1);
    // R8 / R4 level line 0
    chk_irq(1'b0, "R8");
    irq_lines[0] = 1'b1;
    step();
    chk_irq(1'b1, "R8");
    rd(B0 + O_PEND, 32'h1, "R4");
    irq_lines[0] = 1'b0;
    step();
    chk_irq(1'b0, "R4");
    rd(B0 + O_STCLR, 32'h0, "R4");
    // R4 disabled level line shows raw but not pending
    irq_lines[5] = 1'b1;
    step();
    rd(B0 + O_STCLR, 32'h20, "R4");
    rd(B0 + O_PEND, 32'h0, "R4");
    chk_irq(1'b0, "R4");
    irq_lines[5] = 1'b0;
    // R5 edge line 1
    wr(B0 + O_TYPE, 32'h2);
    irq_lines[1] = 1'b1;
    step();
    irq_lines[1] = 1'b0;
    step();
    chk_irq(1'b1, "R5");
    rd(B0 + O_STCLR, 32'h2, "R5");
    wr(B0 + O_STCLR, 32'h2);
    step();
    chk_irq(1'b0, "R5");
    rd(B0 + O_STCLR, 32'h0, "R5");
    // R6 edge and clear in the same cycle
    irq_lines[1] = 1'b1;
    wr(B0 + O_STCLR, 32'h2);
    rd(B0 + O_STCLR, 32'h2, "R6");
    irq_lines[1] = 1'b0;
    wr(B0 + O_STCLR, 32'h2);
    rd(B0 + O_STCLR, 32'h0, "R6");
    step();
    chk_irq(1'b0, "R6");
    // R7 software trigger on line 3
    wr(B0 + O_SW, 32'h8);
    step();
    chk_irq(1'b1, "R7");
    rd(B0 + O_SW, 32'h0, "R7");
    rd(B0 + O_STCLR, 32'h8, "R7");
    // R10 / R9 output enable vs master status
    wr(A_OEN, 32'd0);
    step();
    chk_irq(1'b0, "R10");
    rd(A_MSTAT, 32'd1, "R9");
    rd(B0 + O_STCLR, 32'h8, "R10");
    wr(A_OEN, 32'd1);
    step();
    chk_irq(1'b1, "R10");
    wr(A_MST, 32'd0);
    step();
    chk_irq(1'b0, "R8");
    rd(A_MSTAT, 32'd0, "R9");
    wr(A_MST, 32'd1);
    step();
    chk_irq(1'b1, "R8");
    wr(B0 + O_STCLR, 32'h8);
    step();
    chk_irq(1'b0, "R7");
    // R11 second bank
    wr(B1 + O_ENSET, 32'h8000_0000);
    irq_lines[63] = 1'b1;
    step();
    chk_irq(1'b1, "R11");
    rd(B1 + O_PEND, 32'h8000_0000, "R11");
    rd(B0 + O_PEND, 32'h0, "R11");
    irq_lines[63] = 1'b0;
    step();
    chk_irq(1'b0, "R11");
    // R12 read-only, unmapped and unaligned accesses
    wr(A_ID, 32'hFFFF_FFFF);
    rd(A_ID, 32'h0102_0040, "R12");
    wr(B0 + O_PEND, 32'hFF);
    rd(B0 + O_STCLR, 32'h0, "R12");
    wr(10'h3FC, 32'hFFFF_FFFF);
    wr(B0 + O_ENCLR + 10'h1, 32'hFFFF_FFFF);
    rd(B0 + O_ENSET, 32'h0000_010F, "R12");
    rd(10'h3FC, 32'h0, "R12");
    step();
    if (sb.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard: got %0d leftover expected 0", sb.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule